// File: doc/BRIEF.md
# Write-Data ECC Fault Injector

This block sits in the write-data path of a DRAM controller, just ahead of the ECC encoder output. It corrupts chosen bits of chosen beats on selected write bursts, so that the error detection and correction logic downstream can be tested with known single-bit or multi-bit faults. Each burst is announced by a start-of-burst beat that carries the decoded DRAM address fields, a scrub flag, a channel number and a burst-length select. The block compares the packed address against a programmable mask and match pair. On a qualifying burst it XORs the channel's flip pattern into the beats that the channel's beat-select mask names.

Software programs the block through a simple register write port, and only while no burst is in flight. A control register holds an enable bit and a persistent bit. With persistent set, every qualifying burst is corrupted. With persistent clear, the block corrupts the first qualifying burst and then disarms itself until the enable bit is written again from 0 to 1. A sticky output reports that at least one injection has taken place. Scrub bursts always pass through untouched. All data, corrupted or not, goes through exactly one register stage.

The controller is a two-state machine. **IDLE** waits for a start beat. The transition **IDLE→BURST** (start beat with valid) latches the qualify decision, the channel and the burst length. **BURST→BURST** advances the beat count on each valid beat. **BURST→IDLE** is taken on the valid beat whose index equals the last beat of the burst.

Top module: `wdata_fault_inject`

## Requirements
- R1: After reset, dout_vld and fired are 0, dout is all zeros, and injection is disabled (the control register reads as enable=0, persistent=0).
- R2: dout_vld and dout follow din_vld and din by exactly one clock. A beat that is not corrupted leaves the block unchanged.
- R3: The address is packed as {sub, lrank, rank, bg, bank, col, row}, with row in the low bits. A burst qualifies only if every address bit whose mask bit is 0 equals the match bit. Bits whose mask bit is 1 are ignored. Register 0 holds mask bits 31:0, register 1 holds mask bits 37:32, register 2 holds match bits 31:0 and register 3 holds match bits 37:32.
- R4: With the control register (address 4) bit 0 (enable) at 0, no beat is corrupted.
- R5: With enable=1 and control bit 1 (persistent)=1, every qualifying burst is corrupted.
- R6: With enable=1 and persistent=0, only the first qualifying burst after the block is armed is corrupted. The block is armed by a control write that sets enable while enable was 0.
- R7: Bit k of a channel's beat-select register corrupts beat k of the burst, where beat 0 is the start beat and the count advances on valid beats only.
- R8: The flip pattern is {C[7:0], B[31:0], A[31:0]} XORed onto the 72-bit bus. Bit n of word A inverts data bit n, word B covers bits 63:32, and the low 8 bits of word C cover the check lanes 71:64.
- R9: A burst whose start beat has txn_scrub=1 is never corrupted, even when its address qualifies.
- R10: Channel 0 uses registers 5 (beat select), 6 (A), 7 (B) and 8 (C). Channel 1 uses registers 9, 10, 11 and 12. The txn_chan value on the start beat selects the set for the whole burst.
- R11: fired goes to 1 on the first corrupted burst and stays at 1 until a write to the control register clears it. Writes to other registers leave it set.
- R12: A register write is ignored while a burst is in flight, and also in a cycle that carries a valid start beat. The qualify decision taken at the start beat holds for the whole burst.
- R13: txn_len16=1 on the start beat gives a 16-beat burst; txn_len16=0 gives an 8-beat burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register index |
| cfg_wdata | input | 32 | Register write value |
| txn_sob | input | 1 | Start-of-burst marker on the first beat |
| txn_row | input | ROW_W (18) | Row address |
| txn_col | input | COL_W (10) | Column address |
| txn_bank | input | BANK_W (2) | Bank |
| txn_bg | input | BG_W (2) | Bank group |
| txn_rank | input | RANK_W (2) | Rank |
| txn_lrank | input | LRANK_W (3) | Logical rank |
| txn_sub | input | SUB_W (1) | Sub-channel |
| txn_scrub | input | 1 | Burst is a scrub write |
| txn_len16 | input | 1 | 1 = 16-beat burst, 0 = 8-beat burst |
| txn_chan | input | CH_W (1) | Controller channel of the burst |
| din_vld | input | 1 | Input beat valid |
| din | input | DATA_W (72) | Input beat, data and check lanes |
| dout_vld | output | 1 | Output beat valid |
| dout | output | DATA_W (72) | Output beat, possibly corrupted |
| fired | output | 1 | Sticky: an injection has taken place |

## Verification
Two events can meet in one cycle: a register write and a start beat. The block must drop the write, because the qualify decision and the channel are latched on that same edge. The bench provokes this by raising a control write that clears enable on the start beat of a qualifying burst, and again on a middle beat. It then judges the outcome at the ports: the burst in progress keeps its corruption, and a following qualifying burst is still corrupted. A second meeting is between a one-shot injection and the disarm it triggers. Back-to-back qualifying bursts check that the first is corrupted and the second passes through clean.

// File: rtl/fi_pkg.sv
package fi_pkg;
    typedef enum logic {ST_IDLE, ST_BURST} fi_state_e;

    localparam logic [3:0] REG_MASK_LO  = 4'd0;
    localparam logic [3:0] REG_MASK_HI  = 4'd1;
    localparam logic [3:0] REG_MATCH_LO = 4'd2;
    localparam logic [3:0] REG_MATCH_HI = 4'd3;
    localparam logic [3:0] REG_CTRL     = 4'd4;
    localparam int         REG_CH_BASE  = 5;
    localparam int         REG_CH_SPAN  = 4;
endpackage

// File: rtl/fi_addr_cmp.sv
module fi_addr_cmp #(
    parameter int ADDR_W = 38
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] mask,
    input  logic [ADDR_W-1:0] match,
    output logic              hit
);
    // a set mask bit removes that address bit from the compare
    assign hit = ~|((addr ^ match) & ~mask);
endmodule

// File: rtl/fi_cfg_regs.sv
module fi_cfg_regs
    import fi_pkg::*;
#(
    parameter int ADDR_W = 38,
    parameter int DATA_W = 72,
    parameter int NCH    = 2,
    parameter int MAXB   = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_ok,
    input  logic [3:0]                    waddr,
    input  logic [31:0]                   wdata,
    output logic [ADDR_W-1:0]             mask,
    output logic [ADDR_W-1:0]             match,
    output logic                          en,
    output logic                          persist,
    output logic                          rearm,
    output logic                          ctrl_wr,
    output logic [NCH-1:0][MAXB-1:0]      sel,
    output logic [NCH-1:0][DATA_W-1:0]    pat
);
    localparam int HI_W = ADDR_W - 32;

    logic [31:0]     mask_lo, match_lo;
    logic [HI_W-1:0] mask_hi, match_hi;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_lo  <= '0;
            mask_hi  <= '0;
            match_lo <= '0;
            match_hi <= '0;
            en       <= 1'b0;
            persist  <= 1'b0;
        end else if (wr_ok) begin
            unique case (waddr)
                REG_MASK_LO:  mask_lo  <= wdata;
                REG_MASK_HI:  mask_hi  <= wdata[HI_W-1:0];
                REG_MATCH_LO: match_lo <= wdata;
                REG_MATCH_HI: match_hi <= wdata[HI_W-1:0];
                REG_CTRL:     {persist, en} <= wdata[1:0];
                default: ;
            endcase
        end
    end

    assign mask    = {mask_hi, mask_lo};
    assign match   = {match_hi, match_lo};
    assign ctrl_wr = wr_ok && (waddr == REG_CTRL);
    assign rearm   = ctrl_wr && wdata[0] && !en;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        localparam logic [3:0] BASE = 4'(REG_CH_BASE + REG_CH_SPAN * c);
        logic [MAXB-1:0] sel_q;
        logic [31:0]     wa_q, wb_q;
        logic [7:0]      wc_q;
        logic [63:0]     wide;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_q <= '0;
                wa_q  <= '0;
                wb_q  <= '0;
                wc_q  <= '0;
            end else if (wr_ok) begin
                if (waddr == BASE)        sel_q <= wdata[MAXB-1:0];
                if (waddr == BASE + 4'd1) wa_q  <= wdata;
                if (waddr == BASE + 4'd2) wb_q  <= wdata;
                if (waddr == BASE + 4'd3) wc_q  <= wdata[7:0];
            end
        end

        assign wide   = {wb_q, wa_q};
        assign sel[c] = sel_q;
        // check-lane word always lands on the top 8 lanes of the bus
        assign pat[c] = {wc_q, wide[DATA_W-9:0]};
    end
endmodule

// File: rtl/fi_burst_fsm.sv
module fi_burst_fsm
    import fi_pkg::*;
#(
    parameter int MAXB        = 16,
    parameter int SHORT_BEATS = 8,
    parameter int CH_W        = 1,
    localparam int BW         = $clog2(MAXB)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            vld,
    input  logic            sob,
    input  logic            len_long,
    input  logic            qual,
    input  logic            persist,
    input  logic            rearm,
    input  logic            ctrl_wr,
    input  logic [CH_W-1:0] chan_in,
    output logic            idle,
    output logic [BW-1:0]   beat,
    output logic            inj,
    output logic [CH_W-1:0] chan_cur,
    output logic            fired,
    output logic            armed
);
    fi_state_e       state_q, state_d;
    logic [BW-1:0]   cnt_q, last_q;
    logic            hit_q;
    logic [CH_W-1:0] chan_q;
    logic            start, hit_now;

    assign idle    = (state_q == ST_IDLE);
    assign start   = idle && vld && sob;
    assign hit_now = start && qual && (persist || armed);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        beat     = cnt_q;
        inj      = hit_q;
        chan_cur = chan_q;
        unique case (state_q)
            ST_IDLE: begin
                beat     = '0;
                inj      = hit_now;
                chan_cur = chan_in;
                if (vld && sob) state_d = ST_BURST;
            end
            ST_BURST: begin
                if (vld && (cnt_q == last_q)) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            last_q <= '0;
            hit_q  <= 1'b0;
            chan_q <= '0;
        end else if (start) begin
            cnt_q  <= BW'(1);
            last_q <= len_long ? BW'(MAXB - 1) : BW'(SHORT_BEATS - 1);
            hit_q  <= hit_now;
            chan_q <= chan_in;
        end else if (!idle && vld) begin
            cnt_q  <= cnt_q + BW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            fired <= 1'b0;
        end else begin
            if (rearm)                    armed <= 1'b1;
            else if (hit_now && !persist) armed <= 1'b0;
            if (ctrl_wr)                  fired <= 1'b0;
            else if (hit_now)             fired <= 1'b1;
        end
    end
endmodule

// File: rtl/wdata_fault_inject.sv
module wdata_fault_inject
    import fi_pkg::*;
#(
    parameter int DATA_W      = 72,
    parameter int ROW_W       = 18,
    parameter int COL_W       = 10,
    parameter int BANK_W      = 2,
    parameter int BG_W        = 2,
    parameter int RANK_W      = 2,
    parameter int LRANK_W     = 3,
    parameter int SUB_W       = 1,
    parameter int NCH         = 2,
    parameter int LONG_BEATS  = 16,
    parameter int SHORT_BEATS = 8,
    localparam int ADDR_W     = ROW_W + COL_W + BANK_W + BG_W + RANK_W + LRANK_W + SUB_W,
    localparam int CH_W       = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int BW         = $clog2(LONG_BEATS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [3:0]         cfg_addr,
    input  logic [31:0]        cfg_wdata,
    input  logic               txn_sob,
    input  logic [ROW_W-1:0]   txn_row,
    input  logic [COL_W-1:0]   txn_col,
    input  logic [BANK_W-1:0]  txn_bank,
    input  logic [BG_W-1:0]    txn_bg,
    input  logic [RANK_W-1:0]  txn_rank,
    input  logic [LRANK_W-1:0] txn_lrank,
    input  logic [SUB_W-1:0]   txn_sub,
    input  logic               txn_scrub,
    input  logic               txn_len16,
    input  logic [CH_W-1:0]    txn_chan,
    input  logic               din_vld,
    input  logic [DATA_W-1:0]  din,
    output logic               dout_vld,
    output logic [DATA_W-1:0]  dout,
    output logic               fired
);
    logic [ADDR_W-1:0]                 addr, mask, match;
    logic                              en, persist, rearm, ctrl_wr, addr_hit, qual;
    logic                              idle, inj, armed, cfg_ok;
    logic [BW-1:0]                     beat;
    logic [CH_W-1:0]                   chan_cur;
    logic [NCH-1:0][LONG_BEATS-1:0]    sel;
    logic [NCH-1:0][DATA_W-1:0]        pat;
    logic [DATA_W-1:0]                 flip;

    assign addr   = {txn_sub, txn_lrank, txn_rank, txn_bg, txn_bank, txn_col, txn_row};
    assign cfg_ok = cfg_we && idle && !(din_vld && txn_sob);
    assign qual   = en && addr_hit && !txn_scrub;

    fi_cfg_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCH(NCH), .MAXB(LONG_BEATS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_ok(cfg_ok), .waddr(cfg_addr), .wdata(cfg_wdata),
        .mask(mask), .match(match), .en(en), .persist(persist),
        .rearm(rearm), .ctrl_wr(ctrl_wr), .sel(sel), .pat(pat)
    );

    fi_addr_cmp #(.ADDR_W(ADDR_W)) u_cmp (
        .addr(addr), .mask(mask), .match(match), .hit(addr_hit)
    );

    fi_burst_fsm #(
        .MAXB(LONG_BEATS), .SHORT_BEATS(SHORT_BEATS), .CH_W(CH_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .vld(din_vld), .sob(txn_sob), .len_long(txn_len16),
        .qual(qual), .persist(persist), .rearm(rearm), .ctrl_wr(ctrl_wr),
        .chan_in(txn_chan), .idle(idle), .beat(beat), .inj(inj),
        .chan_cur(chan_cur), .fired(fired), .armed(armed)
    );

    assign flip = (inj && sel[chan_cur][beat]) ? pat[chan_cur] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_vld <= 1'b0;
            dout     <= '0;
        end else begin
            dout_vld <= din_vld;
            dout     <= din ^ flip;
        end
    end
endmodule

// File: rtl/fi_inject_chk.sv
module fi_inject_chk #(
    parameter int DATA_W = 72
) (
    input logic              clk,
    input logic              rst_n,
    input logic              din_vld,
    input logic [DATA_W-1:0] din,
    input logic              txn_sob,
    input logic              txn_scrub,
    input logic              cfg_we,
    input logic              dout_vld,
    input logic [DATA_W-1:0] dout,
    input logic              fired,
    input logic              idle,
    input logic              inj,
    input logic              en,
    input logic              persist,
    input logic              armed
);
    // R2
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        din_vld |=> dout_vld);
    // R2
    vld_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !din_vld |=> !dout_vld);
    // R9
    scrub_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && din_vld && txn_sob && txn_scrub) |=> (dout == $past(din)));
    // R4
    off_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && din_vld && txn_sob && !en) |=> (dout == $past(din)));
    // R11
    fired_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fired && !cfg_we) |=> fired);
    // R6
    oneshot_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && inj && !persist) |=> !armed);
    // R12
    busy_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && cfg_we) |=> ($stable(en) && $stable(persist)));
endmodule

bind wdata_fault_inject fi_inject_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .din_vld(din_vld), .din(din), .txn_sob(txn_sob),
    .txn_scrub(txn_scrub), .cfg_we(cfg_we), .dout_vld(dout_vld), .dout(dout),
    .fired(fired), .idle(idle), .inj(inj), .en(en), .persist(persist), .armed(armed)
);

// File: tb/sim_wdata_fault_inject.sv
module sim_wdata_fault_inject;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        txn_sob = 1'b0;
    logic [17:0] txn_row = '0;
    logic [9:0]  txn_col = '0;
    logic [1:0]  txn_bank = '0, txn_bg = '0, txn_rank = '0;
    logic [2:0]  txn_lrank = '0;
    logic [0:0]  txn_sub = '0;
    logic        txn_scrub = 1'b0, txn_len16 = 1'b0;
    logic [0:0]  txn_chan = '0;
    logic        din_vld = 1'b0;
    logic [71:0] din = '0;
    logic        dout_vld, fired;
    logic [71:0] dout;

    int checks = 0;
    int errors = 0;

    // bench model of the programmed state
    logic [37:0] m_mask = '0, m_match = '0;
    logic        m_en = 1'b0, m_pers = 1'b0, m_armed = 1'b0, m_fired = 1'b0;
    logic [15:0] m_sel [2];
    logic [31:0] m_fa [2], m_fb [2];
    logic [7:0]  m_fc [2];

    always #10 clk = ~clk;

    wdata_fault_inject u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .txn_sob(txn_sob), .txn_row(txn_row), .txn_col(txn_col), .txn_bank(txn_bank),
        .txn_bg(txn_bg), .txn_rank(txn_rank), .txn_lrank(txn_lrank), .txn_sub(txn_sub),
        .txn_scrub(txn_scrub), .txn_len16(txn_len16), .txn_chan(txn_chan),
        .din_vld(din_vld), .din(din), .dout_vld(dout_vld), .dout(dout), .fired(fired)
    );

    task automatic check(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [71:0] pat_of(input int ch);
        return {m_fc[ch], m_fb[ch], m_fa[ch]};
    endfunction

    function automatic bit qualifies(input logic [37:0] a, input bit scrub);
        return m_en && (m_pers || m_armed) && !scrub && (((a ^ m_match) & ~m_mask) == '0);
    endfunction

    task automatic cfg_write(input logic [3:0] ad, input logic [31:0] v);
        cfg_we = 1'b1; cfg_addr = ad; cfg_wdata = v;
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b0;
        case (ad)
            4'd0: m_mask[31:0]  = v;
            4'd1: m_mask[37:32] = v[5:0];
            4'd2: m_match[31:0] = v;
            4'd3: m_match[37:32]= v[5:0];
            4'd4: begin
                if (v[0] && !m_en) m_armed = 1'b1;
                m_en = v[0]; m_pers = v[1]; m_fired = 1'b0;
            end
            4'd5: m_sel[0] = v[15:0];
            4'd6: m_fa[0] = v;
            4'd7: m_fb[0] = v;
            4'd8: m_fc[0] = v[7:0];
            4'd9: m_sel[1] = v[15:0];
            4'd10: m_fa[1] = v;
            4'd11: m_fb[1] = v;
            4'd12: m_fc[1] = v[7:0];
            default: ;
        endcase
    endtask

    // drives one burst; cfg_beat >= 0 raises an ignored control write (enable off) on that beat
    task automatic send_burst(input logic [37:0] a, input bit scrub, input int ch,
                              input bit l16, input int cfg_beat, input string tag);
        bit hit = qualifies(a, scrub);
        int nb = l16 ? 16 : 8;
        if (hit && !m_pers) m_armed = 1'b0;
        if (hit) m_fired = 1'b1;
        for (int b = 0; b < nb; b++) begin
            logic [71:0] d, e;
            d[31:0]  = $urandom();
            d[63:32] = $urandom();
            d[71:64] = 8'($urandom());
            e = d ^ ((hit && m_sel[ch][b]) ? pat_of(ch) : 72'd0);
            din_vld = 1'b1; din = d; txn_sob = (b == 0);
            {txn_sub, txn_lrank, txn_rank, txn_bg, txn_bank, txn_col, txn_row} = a;
            txn_scrub = scrub; txn_len16 = l16; txn_chan = 1'(ch);
            if (b == cfg_beat) begin
                cfg_we = 1'b1; cfg_addr = 4'd4; cfg_wdata = 32'd0;
            end
            @(posedge clk); @(negedge clk);
            cfg_we = 1'b0;
            check(dout_vld == 1'b1, {tag, " R2 vld"}, 72'(dout_vld), 72'd1);
            check(dout == e, tag, dout, e);
        end
        din_vld = 1'b0; txn_sob = 1'b0; txn_scrub = 1'b0;
        @(posedge clk); @(negedge clk);
        check(dout_vld == 1'b0, "R2 idle vld", 72'(dout_vld), 72'd0);
        check(fired == m_fired, {tag, " R11 fired"}, 72'(fired), 72'(m_fired));
    endtask

    localparam logic [37:0] HOME = {1'b0, 3'd0, 2'd0, 2'd0, 2'd0, 10'h020, 18'h00002};

    initial begin
        repeat (2000 * 20) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd9173));
        for (int c = 0; c < 2; c++) begin
            m_sel[c] = '0; m_fa[c] = '0; m_fb[c] = '0; m_fc[c] = '0;
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        check(dout_vld == 1'b0, "R1 dout_vld", 72'(dout_vld), 72'd0);
        check(fired == 1'b0, "R1 fired", 72'(fired), 72'd0);
        check(dout == '0, "R1 dout", dout, 72'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: nothing enabled yet, matching burst passes
        send_burst(38'd0, 1'b0, 0, 1'b0, -1, "R1 disabled");

        cfg_write(4'd2, HOME[31:0]);
        cfg_write(4'd3, 32'(HOME[37:32]));
        cfg_write(4'd5, 32'h0000_0001);
        cfg_write(4'd6, 32'h8000_0008);
        cfg_write(4'd9, 32'h0000_8002);
        cfg_write(4'd10, 32'h0000_0000);
        cfg_write(4'd11, 32'h0000_0001);
        cfg_write(4'd12, 32'h0000_00A5);
        cfg_write(4'd4, 32'd3);
        // R8 bits 31 and 3 of beat 0, R7 beat 0 only
        send_burst(HOME, 1'b0, 0, 1'b0, -1, "R8 R7 ch0 flip");
        // R5 persistent: again
        send_burst(HOME, 1'b0, 0, 1'b0, -1, "R5 persistent");
        // R3 row mismatch
        send_burst(HOME ^ 38'd1, 1'b0, 0, 1'b0, -1, "R3 mismatch");
        // R3 row masked
        cfg_write(4'd0, 32'h0003_FFFF);
        send_burst(HOME ^ 38'h1_2345, 1'b0, 0, 1'b0, -1, "R3 masked");
        send_burst(HOME ^ (38'd1 << 20), 1'b0, 0, 1'b0, -1, "R3 unmasked col");
        cfg_write(4'd0, 32'd0);
        // R9 scrub
        send_burst(HOME, 1'b1, 0, 1'b0, -1, "R9 scrub");
        // R10 channel 1, R13 16 beats with beat 15, R8 check lanes
        send_burst(HOME, 1'b0, 1, 1'b1, -1, "R10 R13 ch1 long");
        send_burst(HOME, 1'b0, 0, 1'b1, -1, "R13 ch0 long");
        // R6 one-shot
        cfg_write(4'd4, 32'd0);
        cfg_write(4'd4, 32'd1);
        send_burst(HOME, 1'b0, 0, 1'b0, -1, "R6 first");
        send_burst(HOME, 1'b0, 0, 1'b0, -1, "R6 second");
        cfg_write(4'd4, 32'd1);
        send_burst(HOME, 1'b0, 0, 1'b0, -1, "R6 no rearm");
        cfg_write(4'd4, 32'd0);
        cfg_write(4'd4, 32'd1);
        send_burst(HOME, 1'b0, 1, 1'b0, -1, "R6 rearmed");
        // R4 disabled
        cfg_write(4'd4, 32'd0);
        check(fired == 1'b0, "R11 cleared", 72'(fired), 72'd0);
        send_burst(HOME, 1'b0, 0, 1'b0, -1, "R4 disabled");
        // R11 sticky across other writes
        cfg_write(4'd4, 32'd3);
        send_burst(HOME, 1'b0, 0, 1'b0, -1, "R11 set");
        cfg_write(4'd5, 32'h0000_00FF);
        check(fired == 1'b1, "R11 sticky", 72'(fired), 72'd1);
        // R12 writes while busy or on start beat are ignored
        send_burst(HOME, 1'b0, 0, 1'b0, 3, "R12 mid write");
        send_burst(HOME, 1'b0, 0, 1'b0, 0, "R12 start write");
        send_burst(HOME, 1'b0, 0, 1'b0, -1, "R12 still enabled");

        // random mix
        cfg_write(4'd0, 32'h00F0_000F);
        for (int i = 0; i < 150; i++) begin
            logic [37:0] a = HOME;
            if ($urandom() % 2 == 1) a[$urandom() % 38] ^= 1'b1;
            if ($urandom() % 3 == 0) a[$urandom() % 4] ^= 1'b1;
            if ($urandom() % 20 == 0) cfg_write(4'd4, 32'($urandom() % 4));
            if ($urandom() % 25 == 0) cfg_write(4'(5 + ($urandom() % 8)), $urandom());
            send_burst(a, ($urandom() % 8) == 0, int'($urandom() % 2), 1'($urandom()), -1, "R3 R7 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule